// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the device end of a small serial EEPROM on a four-wire serial bus. The four wires are an active-low select, a serial clock, data into the device and data out of it. It holds a byte-addressed storage array built from flip-flops. A host uses it through four one-byte commands:

- 0x03 reads bytes in sequence.
- 0x06 sets the write-enable latch.
- 0x02 writes one byte.
- 0x05 reads the status byte.

A write finishes in a self-timed cycle whose length, counted in system clocks, is set by a parameter.

The bus pins are brought into the system clock domain through two-flop synchronizers and then edge-detected, so the whole block runs on one clock. Bits are taken in on the rising serial clock edge, most significant bit first. The output bit changes after each falling edge. The output driver is released whenever the device is not sending a read or status byte. A write only takes effect if two things hold: the latch was armed by an earlier enable command, and select is released right after the eighth data bit.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, status is 0x00, every storage byte is 0x00 and the output is not driven (miso_oe low).
- R2: Input bits are taken on rising serial clock edges, MSB first; each output bit becomes valid after a falling edge, MSB first, and holds until the next falling edge.
- R3: Command 0x03 followed by an address byte returns the stored byte at that address.
- R4: Further clocks during a read return following addresses in order, wrapping from the top address (0xFF by default) to 0x00.
- R5: miso_oe is low while select is high, during the command and address bytes, and again within a few clocks after select rises during a read.
- R6: Command 0x06 sets the write-enable latch (status bit 1) when select rises after it.
- R7: Command 0x02, an address and one data byte, with select released right after the eighth data bit, starts a write cycle: status bit 0 is high for WR_CYCLES clocks. At its end the byte is stored and the write-enable latch clears.
- R8: A write whose select release comes before the eighth data bit or after extra clocks is cancelled: no write cycle, storage unchanged, latch still set.
- R9: A write command while the latch is clear is ignored: no write cycle, storage unchanged.
- R10: A read command during a write cycle is rejected: the output stays released until the next select.
- R11: Command 0x05 returns status {4'b0, BP1, BP0, latch, busy} with BP bits zero; it is accepted during a write cycle and repeats with live values on every further byte.
- R12: An unknown command makes the device ignore all further bits until deselect, with no output and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out, high impedance when not driven |
| miso_oe | output | 1 | High while the device drives miso |

## Verification
Reads are tried with bytes of mixed bit patterns (0xA5, 0x3C, 0xC3, 0x77). A swapped bit order or a wrong sampling edge therefore shows up as a wrong value. Sequential reads that cross the top address separate correct wrap-around from a stuck or saturating counter. Writes are tried in several forms: without an armed latch, with select released one bit early, with one bit extra, and after an unknown command. Each of these separates the exact acceptance window from a looser one. Status is read during and after a write cycle, and a read is attempted inside one. This tells the busy and latch bits, and the read rejection, apart from an immediate write.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output wire  miso,
  output logic miso_oe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WCNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    P_CMD, P_ADDR, P_WDATA, P_WDONE, P_RD, P_STAT, P_WEN, P_IGN
  } phase_t;

  logic [2:0] cs_sy, sck_sy;
  logic [1:0] mosi_sy;
  phase_t     phase;
  logic [6:0] rx_sh;
  logic [2:0] icnt, ocnt;
  logic       is_wr, miso_q, wel, wip;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, obuf;
  logic [WCNT_W-1:0] wcnt;
  logic [7:0] mem [DEPTH];

  wire cs_q     = cs_sy[1];
  wire cs_rise  = cs_sy[1] & ~cs_sy[2];
  wire sck_rise = sck_sy[1] & ~sck_sy[2];
  wire sck_fall = ~sck_sy[1] & sck_sy[2];
  wire [7:0] rx_byte = {rx_sh, mosi_sy[1]};
  wire [7:0] status  = {4'b0000, 2'b00, wel, wip};
  wire [ADDR_W-1:0] addr_nx = addr + 1'b1;
  wire [ADDR_W-1:0] rx_addr = rx_byte[ADDR_W-1:0];
  wire wr_done = wip && (wcnt == WCNT_W'(1));

  assign miso_oe = ~cs_q & (phase == P_RD || phase == P_STAT);
  assign miso    = miso_oe ? miso_q : 1'bz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy   <= '1;
      sck_sy  <= '0;
      mosi_sy <= '0;
    end else begin
      cs_sy   <= {cs_sy[1:0], cs_n};
      sck_sy  <= {sck_sy[1:0], sck};
      mosi_sy <= {mosi_sy[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_done) begin
      mem[addr] <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= P_CMD;
      rx_sh  <= '0;
      icnt   <= '0;
      ocnt   <= '0;
      is_wr  <= 1'b0;
      miso_q <= 1'b0;
      wel    <= 1'b0;
      wip    <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      obuf   <= '0;
      wcnt   <= '0;
    end else begin
      if (wip) begin
        wcnt <= wcnt - 1'b1;
        if (wr_done) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end
      if (cs_q) begin
        if (cs_rise && phase == P_WEN) wel <= 1'b1;
        if (cs_rise && phase == P_WDONE) begin
          wip  <= 1'b1;
          wcnt <= WCNT_W'(WR_CYCLES);
        end
        phase <= P_CMD;
        icnt  <= '0;
        ocnt  <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh <= rx_byte[6:0];
          icnt  <= icnt + 1'b1;
          case (phase)
            P_CMD: if (icnt == 3'd7) begin
              case (rx_byte)
                OP_WREN: phase <= wip ? P_IGN : P_WEN;
                OP_RDSR: begin
                  phase <= P_STAT;
                  obuf  <= status;
                  ocnt  <= '0;
                end
                OP_READ: begin
                  phase <= wip ? P_IGN : P_ADDR;
                  is_wr <= 1'b0;
                end
                OP_WRIT: begin
                  phase <= (wel && !wip) ? P_ADDR : P_IGN;
                  is_wr <= 1'b1;
                end
                default: phase <= P_IGN;
              endcase
            end
            P_ADDR: if (icnt == 3'd7) begin
              addr <= rx_addr;
              if (is_wr) phase <= P_WDATA;
              else begin
                phase <= P_RD;
                obuf  <= mem[rx_addr];
                ocnt  <= '0;
              end
            end
            P_WDATA: if (icnt == 3'd7) begin
              wdata <= rx_byte;
              phase <= P_WDONE;
            end
            P_WDONE: phase <= P_IGN;
            default: ;
          endcase
        end
        if (sck_fall && (phase == P_RD || phase == P_STAT)) begin
          miso_q <= obuf[7];
          ocnt   <= ocnt + 1'b1;
          if (ocnt == 3'd7) begin
            if (phase == P_RD) begin
              addr <= addr_nx;
              obuf <= mem[addr_nx];
            end else begin
              obuf <= status;
            end
          end else begin
            obuf <= {obuf[6:0], 1'b0};
          end
        end
      end
    end

  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) cs_q |=> !miso_oe); // R5
  AST_WEL_SET_BY_WREN: assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> $past(phase) == P_WEN); // R6
  AST_WEL_END:      assert property (@(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel); // R7
  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(wel)); // R9
  AST_WIP_NO_READ:  assert property (@(posedge clk) disable iff (!rst_n) wip |-> phase != P_RD); // R10
  AST_ADDR_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                      (sck_fall && !cs_q && phase == P_RD && ocnt == 3'd7) |=> addr == $past(addr_nx)); // R4

endmodule

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb_top;

  localparam int HALF = 8;
  localparam int WR   = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  wire  miso;
  logic miso_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic cap_en = 1'b0;
  logic [7:0] mon_sh = '0;
  int mon_n = 0;
  logic mon_oe_ok = 1'b1;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(8), .WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge sck) if (cap_en) begin
    mon_sh = {mon_sh[6:0], miso};
    if (!miso_oe) mon_oe_ok = 1'b0;
    mon_n++;
    if (mon_n == 8) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", mon_sh, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mon_sh == e && mon_oe_ok, t, mon_sh, e);
      end
      mon_n = 0;
      mon_oe_ok = 1'b1;
    end
  end

  task automatic expect_byte(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic bit_cycle(input logic b);
    mosi = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_cycle(b[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic wren();
    sel(); put_byte(8'h06); desel();
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
    sel(); put_byte(8'h02); put_byte(a); put_byte(d); desel();
  endtask

  task automatic read_seq(input logic [7:0] a, input int n);
    sel(); put_byte(8'h03); put_byte(a);
    cap_en = 1'b1;
    for (int i = 0; i < n; i++) put_byte(8'h00);
    cap_en = 1'b0;
    desel();
  endtask

  task automatic rd_status(input logic [7:0] e, input int n, input string t);
    sel(); put_byte(8'h05);
    for (int i = 0; i < n; i++) expect_byte(e, t);
    cap_en = 1'b1;
    for (int i = 0; i < n; i++) put_byte(8'h00);
    cap_en = 1'b0;
    desel();
  endtask

  task automatic wait_write();
    repeat (WR + 50) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miso_oe == 1'b0, "R1 output released", miso_oe, 0);
    rd_status(8'h00, 1, "R1 R11 reset status");
    expect_byte(8'h00, "R1 reset storage");
    read_seq(8'h80, 1);

    // R5: released during command and address, and after an early deselect
    sel(); put_byte(8'h03);
    check(miso_oe == 1'b0, "R5 command phase", miso_oe, 0);
    put_byte(8'h10);
    check(miso_oe == 1'b1, "R5 R2 output phase", miso_oe, 1);
    bit_cycle(1'b0); bit_cycle(1'b0); bit_cycle(1'b0);
    desel();
    check(miso_oe == 1'b0, "R5 read ends on deselect", miso_oe, 0);

    // R9: write without the latch
    write_byte(8'h10, 8'h5A);
    rd_status(8'h00, 1, "R9 no write cycle");
    expect_byte(8'h00, "R9 storage unchanged");
    read_seq(8'h10, 1);

    // R6, R7, R11, R10
    wren();
    rd_status(8'h02, 1, "R6 latch set");
    write_byte(8'h10, 8'hA5);
    rd_status(8'h03, 2, "R11 R7 busy status repeats");
    sel(); put_byte(8'h03); put_byte(8'h10);
    bit_cycle(1'b0); bit_cycle(1'b0); bit_cycle(1'b0);
    check(miso_oe == 1'b0, "R10 read rejected while busy", miso_oe, 0);
    desel();
    wait_write();
    rd_status(8'h00, 1, "R7 latch cleared after cycle");
    expect_byte(8'hA5, "R7 R3 stored byte");
    read_seq(8'h10, 1);

    // R4 wrap
    wren(); write_byte(8'hFF, 8'h3C); wait_write();
    wren(); write_byte(8'h00, 8'hC3); wait_write();
    wren(); write_byte(8'h01, 8'h77); wait_write();
    expect_byte(8'h00, "R4 wrap 0xFE");
    expect_byte(8'h3C, "R4 wrap 0xFF");
    expect_byte(8'hC3, "R4 wrap 0x00");
    expect_byte(8'h77, "R4 wrap 0x01");
    read_seq(8'hFE, 4);
    expect_byte(8'h00, "R3 R4 seq 0x0F");
    expect_byte(8'hA5, "R3 R4 seq 0x10");
    expect_byte(8'h00, "R3 R4 seq 0x11");
    read_seq(8'h0F, 3);

    // R8: early and late select release
    wren();
    sel(); put_byte(8'h02); put_byte(8'h20);
    for (int i = 0; i < 7; i++) bit_cycle(1'b1);
    desel();
    rd_status(8'h02, 1, "R8 early release cancelled");
    sel(); put_byte(8'h02); put_byte(8'h20); put_byte(8'hFF); bit_cycle(1'b1);
    desel();
    rd_status(8'h02, 1, "R8 late release cancelled");
    expect_byte(8'h00, "R8 storage unchanged");
    read_seq(8'h20, 1);

    // R12: unknown command ignored
    sel(); put_byte(8'hA5); put_byte(8'h03); put_byte(8'h10);
    bit_cycle(1'b0); bit_cycle(1'b0);
    check(miso_oe == 1'b0, "R12 no output after unknown command", miso_oe, 0);
    desel();
    rd_status(8'h02, 1, "R12 state unchanged");
    write_byte(8'h20, 8'h99);
    wait_write();
    expect_byte(8'h99, "R7 write after ignored command");
    read_seq(8'h20, 1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule